// File: doc/BRIEF.md
# Bidirectional-Bus Universal Shift Register

This block is a parameterised register, eight bits wide by default, that can keep its value, move its contents one place in either direction, or take a whole word from a shared set of bidirectional data lines. The same lines carry the register contents out, so one bus serves as both the parallel input and the parallel output.

A 2-bit mode input picks the operation on each rising clock edge. Two active-low output enables decide whether the register drives the bus. In load mode the block releases the bus without regard to the enables, so an external source can put a word on it. An active-low clear zeroes the register at the next rising edge and takes precedence over every mode.

Each end bit has its own serial output that drives at all times. Several copies can therefore be chained into a longer word through the serial path, even when their buses are released. A synchronous active-high reset puts the register at zero.

Top module: `usr_shift_reg`

## Requirements
- R1: With mode_sel = 2'b00 (hold) and clr_n high, the register keeps its value across clock edges.
- R2: With mode_sel = 2'b01 (shift toward the high end), each rising edge moves bit i to bit i+1 and loads ser_up_in into bit 0.
- R3: With mode_sel = 2'b10 (shift toward the low end), each rising edge moves bit i to bit i-1 and loads ser_down_in into the top bit.
- R4: With mode_sel = 2'b11 (load), the rising edge copies the value on data_io into the register.
- R5: While mode_sel = 2'b11, data_io is high impedance for every setting of oe_a_n and oe_b_n.
- R6: Outside load mode, data_io carries the register contents when oe_a_n and oe_b_n are both low. It is high impedance when either of them is high.
- R7: When clr_n is low at a rising edge, the register becomes zero, whatever the mode, load included. A low clr_n has no effect between edges.
- R8: end_lo_out always equals register bit 0 and end_hi_out always equals the top bit, including while data_io is released.
- R9: When rst is high at a rising edge, the register becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Operation: 00 hold, 01 shift up, 10 shift down, 11 load |
| oe_a_n | input | 1 | Output enable A, active low |
| oe_b_n | input | 1 | Output enable B, active low |
| clr_n | input | 1 | Synchronous clear, active low |
| ser_up_in | input | 1 | Serial bit entering bit 0 in shift-up mode |
| ser_down_in | input | 1 | Serial bit entering the top bit in shift-down mode |
| data_io | inout | WIDTH | Shared parallel input/output bus |
| end_lo_out | output | 1 | Always-driven copy of bit 0 |
| end_hi_out | output | 1 | Always-driven copy of the top bit |

## Verification
The assertions assume that the bus carries a fully known value at any rising edge taken in load mode. They also assume that nothing outside the block drives the bus while the block may be driving it. The stimulus drives data_io from the bench only while mode_sel is 11. It releases the bus whenever it leaves load mode. The high-impedance check in load mode happens between edges, and the bench puts a real word on the bus before the next edge arrives.

// File: rtl/usr_pkg.sv
package usr_pkg;
    localparam int unsigned REG_W = 8;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_UP    = 2'b01,
        OP_DOWN  = 2'b10,
        OP_LOAD  = 2'b11
    } op_e;

    typedef struct packed {
        op_e  op;
        logic bus_drive;
        logic clear;
    } ctrl_t;

    function automatic logic both_low(input logic a_n, input logic b_n);
        return ~a_n & ~b_n;
    endfunction
endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
    import usr_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    input  logic       clr_n,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl.op        = op_e'(mode_sel);
        ctrl.clear     = ~clr_n;
        ctrl.bus_drive = both_low(oe_a_n, oe_b_n) && (op_e'(mode_sel) != OP_LOAD);
    end
endmodule

// File: rtl/usr_core.sv
module usr_core
    import usr_pkg::*;
#(
    parameter int unsigned WIDTH = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic             ser_up_in,
    input  logic             ser_down_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (ctrl.op)
            OP_HOLD: nxt = q;
            OP_UP:   nxt = {q[WIDTH-2:0], ser_up_in};
            OP_DOWN: nxt = {ser_down_in, q[WIDTH-1:1]};
            OP_LOAD: nxt = par_in;
            default: nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear) q <= '0;
        else                   q <= nxt;
    end
endmodule

// File: rtl/usr_bus_drv.sv
module usr_bus_drv #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             drive,
    input  logic [WIDTH-1:0] q,
    inout  wire  [WIDTH-1:0] bus,
    output logic [WIDTH-1:0] bus_in
);
    assign bus    = drive ? q : {WIDTH{1'bz}};
    assign bus_in = bus;
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int unsigned WIDTH = REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             clr_n,
    input  logic             ser_up_in,
    input  logic             ser_down_in,
    inout  wire  [WIDTH-1:0] data_io,
    output logic             end_lo_out,
    output logic             end_hi_out
);
    ctrl_t            ctrl;
    logic [WIDTH-1:0] q_w;
    logic [WIDTH-1:0] bus_in;

    usr_ctrl ctrl_i (
        .mode_sel (mode_sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .clr_n    (clr_n),
        .ctrl     (ctrl)
    );

    usr_core #(.WIDTH(WIDTH)) core_i (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .ser_up_in   (ser_up_in),
        .ser_down_in (ser_down_in),
        .par_in      (bus_in),
        .q           (q_w)
    );

    usr_bus_drv #(.WIDTH(WIDTH)) bus_i (
        .drive  (ctrl.bus_drive),
        .q      (q_w),
        .bus    (data_io),
        .bus_in (bus_in)
    );

    assign end_lo_out = q_w[0];
    assign end_hi_out = q_w[WIDTH-1];
endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode_sel,
    input logic             oe_a_n,
    input logic             oe_b_n,
    input logic             clr_n,
    input logic             ser_up_in,
    input logic             ser_down_in,
    input logic [WIDTH-1:0] data_io,
    input logic [WIDTH-1:0] q,
    input logic             bus_drive
);
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (clr_n && mode_sel == 2'b00) |=> $stable(q));

    a_r2_shift_up: assert property (@(posedge clk) disable iff (rst)
        (clr_n && mode_sel == 2'b01) |=> q == {$past(q[WIDTH-2:0]), $past(ser_up_in)});

    a_r3_shift_down: assert property (@(posedge clk) disable iff (rst)
        (clr_n && mode_sel == 2'b10) |=> q == {$past(ser_down_in), $past(q[WIDTH-1:1])});

    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (clr_n && mode_sel == 2'b11) |=> q == $past(data_io));

    a_r5_load_release: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'b11) |-> !bus_drive);

    a_r6_bus_shows_reg: assert property (@(posedge clk) disable iff (rst)
        (!oe_a_n && !oe_b_n && mode_sel != 2'b11) |-> data_io == q);

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> q == '0);

    a_r9_reset_zero: assert property (@(posedge clk)
        rst |=> q == '0);
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_sel    (mode_sel),
    .oe_a_n      (oe_a_n),
    .oe_b_n      (oe_b_n),
    .clr_n       (clr_n),
    .ser_up_in   (ser_up_in),
    .ser_down_in (ser_down_in),
    .data_io     (data_io),
    .q           (q_w),
    .bus_drive   (ctrl.bus_drive)
);

// File: tb/usr_shift_reg_tb_top.sv
module usr_shift_reg_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_sel = 2'b00;
    logic         oe_a_n = 1'b1;
    logic         oe_b_n = 1'b1;
    logic         clr_n = 1'b1;
    logic         ser_up_in = 1'b0;
    logic         ser_down_in = 1'b0;
    logic         tb_en = 1'b0;
    logic [W-1:0] tb_val = '0;
    wire  [W-1:0] bus;
    logic         end_lo_out;
    logic         end_hi_out;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    assign bus = tb_en ? tb_val : {W{1'bz}};

    always #10 clk = ~clk;

    usr_shift_reg #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .clr_n(clr_n), .ser_up_in(ser_up_in), .ser_down_in(ser_down_in),
        .data_io(bus), .end_lo_out(end_lo_out), .end_hi_out(end_hi_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_reg(input string req, input logic [W-1:0] exp);
        mode_sel = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0; tb_en = 1'b0;
        #1;
        check(req, bus, exp);
    endtask

    task automatic load_word(input logic [W-1:0] v);
        mode_sel = 2'b11; tb_val = v; tb_en = 1'b1;
        step();
        tb_en = 1'b0; mode_sel = 2'b00;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        read_reg("R9 reset", '0);
        check("R9 reset end outs", {6'b0, end_hi_out, end_lo_out}, '0);
    endtask

    task automatic t_load();
        load_word(8'h5A);
        read_reg("R4 load 5A", 8'h5A);
        load_word(8'hC3);
        read_reg("R4 load C3", 8'hC3);
    endtask

    task automatic t_load_release();
        for (int k = 0; k < 4; k++) begin
            oe_a_n = k[0]; oe_b_n = k[1]; tb_en = 1'b0; mode_sel = 2'b11;
            #1;
            check("R5 load releases bus", bus, {W{1'bz}});
            tb_val = 8'h0F; tb_en = 1'b1;
            #1;
            check("R5 external word visible", bus, 8'h0F);
            step();
            tb_en = 1'b0; mode_sel = 2'b00;
        end
        read_reg("R4 load under any enables", 8'h0F);
    endtask

    task automatic t_enables();
        load_word(8'h96);
        for (int k = 1; k < 4; k++) begin
            mode_sel = 2'b00; oe_a_n = k[0]; oe_b_n = k[1];
            #1;
            check("R6 disabled bus floats", bus, {W{1'bz}});
        end
        read_reg("R6 enabled bus drives", 8'h96);
        mode_sel = 2'b01; oe_a_n = 1'b0; oe_b_n = 1'b0;
        #1;
        check("R6 drives in shift mode", bus, 8'h96);
        mode_sel = 2'b00;
    endtask

    task automatic t_shift_up();
        logic [W-1:0] exp;
        exp = 8'hA5;
        load_word(exp);
        oe_a_n = 1'b1; oe_b_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            mode_sel = 2'b01; ser_up_in = i[0];
            step();
            exp = {exp[W-2:0], i[0]};
            check("R8 end_lo while released", {7'b0, end_lo_out}, {7'b0, exp[0]});
            check("R8 end_hi while released", {7'b0, end_hi_out}, {7'b0, exp[W-1]});
        end
        read_reg("R2 shift up", exp);
    endtask

    task automatic t_shift_down();
        logic [W-1:0] exp;
        exp = 8'h3C;
        load_word(exp);
        for (int i = 0; i < 5; i++) begin
            mode_sel = 2'b10; ser_down_in = ~i[0];
            step();
            exp = {~i[0], exp[W-1:1]};
            check("R8 end_lo", {7'b0, end_lo_out}, {7'b0, exp[0]});
        end
        read_reg("R3 shift down", exp);
    endtask

    task automatic t_hold();
        load_word(8'h81);
        mode_sel = 2'b00; ser_up_in = 1'b1; ser_down_in = 1'b1;
        step(); step(); step();
        read_reg("R1 hold", 8'h81);
    endtask

    task automatic t_clear();
        load_word(8'hFF);
        clr_n = 1'b0; mode_sel = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0;
        #1;
        check("R7 clear waits for edge", bus, 8'hFF);
        clr_n = 1'b1;
        #1;
        read_reg("R7 no clear without edge", 8'hFF);
        mode_sel = 2'b11; tb_val = 8'h77; tb_en = 1'b1; clr_n = 1'b0;
        step();
        tb_en = 1'b0; clr_n = 1'b1;
        read_reg("R7 clear beats load", 8'h00);
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!done) begin
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_load_release();
        t_enables();
        t_shift_up();
        t_shift_down();
        t_hold();
        t_clear();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule